// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block tracks instructions through the front of an in-order five-stage pipeline and decides at a single point whether each one retires or traps. Fault flags from fetch, decode and execute are not acted on when they are raised. Each flag is turned into a cause code and travels with its instruction's PC through the stage registers. At the memory stage, which is the commit point, a data-address fault and any pending external interrupt are added. The block then picks one cause.

When it traps, the block writes the cause and the instruction's PC into its cause and exception-PC registers. In the same cycle it kills the committing instruction and every younger instruction in flight, and it steers fetch to a fixed handler address. Younger instructions that are squashed lose their flags, so they can never trap. The surrounding datapath uses the kill outputs to suppress register and memory writes.

Top module: `exc_commit_ctrl`

## Requirements
- R1: An instruction accepted with `if_valid_i` high and PC p reaches the commit point in the third cycle after acceptance. If nothing traps there, `commit_o` is high and `commit_pc_o` equals p in that cycle.
- R2: Cause codes are 0 none, 1 external interrupt, 2 fetch address fault, 3 illegal opcode, 4 overflow, 5 data address fault. For one instruction, a fault seen in an earlier stage wins over any fault seen in a later stage.
- R3: If `ext_irq_i` is high while an instruction is at the commit point, it overrides every pipeline fault and the recorded cause is 1. With the commit point empty, the interrupt is not taken.
- R4: The clock edge that ends a trap cycle writes the cause into `cause_o` and the committing PC into `epc_o`. Both hold their values in every other cycle.
- R5: In a trap cycle, all four kill outputs are high and `commit_o` is low. The instructions then in fetch, decode and execute are discarded: they neither commit nor trap, whatever flags they carry.
- R6: In a trap cycle, `redirect_o` is high and `redirect_pc_o` equals HANDLER_PC (default 0x180). Outside a trap cycle, `redirect_o` is low.
- R7: Fault flags and interrupts presented while the corresponding stage is empty are ignored: no kill, no redirect, no register update.
- R8: After reset, `cause_o` and `epc_o` are 0 and no kill, redirect or commit is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| if_valid_i | input | 1 | Instruction being fetched this cycle |
| if_pc_i | input | PC_W | PC of fetched instruction |
| if_addr_fault_i | input | 1 | Fetch address fault for fetched instruction |
| id_illegal_i | input | 1 | Illegal opcode for instruction in decode |
| ex_overflow_i | input | 1 | Overflow for instruction in execute |
| mem_addr_fault_i | input | 1 | Data address fault for instruction at commit |
| ext_irq_i | input | 1 | Asynchronous external interrupt request |
| kill_if_o | output | 1 | Squash fetch stage |
| kill_id_o | output | 1 | Squash decode stage |
| kill_ex_o | output | 1 | Squash execute stage |
| kill_mem_o | output | 1 | Squash committing instruction |
| redirect_o | output | 1 | Force fetch PC this cycle |
| redirect_pc_o | output | PC_W | Handler address when redirecting |
| commit_o | output | 1 | Instruction at commit retires |
| commit_pc_o | output | PC_W | PC of retiring instruction |
| cause_o | output | 3 | Recorded trap cause |
| epc_o | output | PC_W | Recorded trapping PC |

## Verification
The assertions check several properties on every cycle. A trap empties every stage register at the next edge. The exception PC captures the trapping instruction's PC. An interrupt at an occupied commit point records cause 1. A stage never lets a later flag replace an older one, and the cause and exception-PC registers stay put outside trap cycles. Other behaviour can only be shown by the bench's scenarios. It sweeps all 32 combinations of fault and interrupt flags on an isolated instruction against an arithmetic priority rule. It checks that flags on empty stages are ignored. It runs a back-to-back stream in which faulting younger instructions must vanish without trapping, followed by an exact commit of the first post-handler fetch.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_IRQ     = 3'd1,
    CAUSE_IFETCH  = 3'd2,
    CAUSE_ILLEGAL = 3'd3,
    CAUSE_OVF     = 3'd4,
    CAUSE_DADDR   = 3'd5
  } cause_e;

  // stage registers between fetch and commit
  localparam int unsigned N_CARRY = 3;

  function automatic cause_e stage_cause(int unsigned k);
    case (k)
      0:       return CAUSE_IFETCH;
      1:       return CAUSE_ILLEGAL;
      default: return CAUSE_OVF;
    endcase
  endfunction

  // older fault wins
  function automatic cause_e merge_cause(cause_e older, logic fault, cause_e local_c);
    if (older != CAUSE_NONE) return older;
    if (fault)               return local_c;
    return CAUSE_NONE;
  endfunction
endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
  import exc_pkg::*;
#(
  parameter int unsigned PC_W        = 32,
  parameter cause_e      LOCAL_CAUSE = CAUSE_IFETCH
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            valid_i,
  input  logic [PC_W-1:0] pc_i,
  input  cause_e          code_i,
  input  logic            fault_i,
  output logic            valid_o,
  output logic [PC_W-1:0] pc_o,
  output cause_e          code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pc_o    <= '0;
      code_o  <= CAUSE_NONE;
    end else if (flush_i) begin
      valid_o <= 1'b0;
      code_o  <= CAUSE_NONE;
    end else begin
      valid_o <= valid_i;
      pc_o    <= pc_i;
      code_o  <= valid_i ? merge_cause(code_i, fault_i, LOCAL_CAUSE) : CAUSE_NONE;
    end
  end

  p_flush_empties_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !valid_o);

  p_older_kept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && valid_i && code_i != CAUSE_NONE) |=> code_o == $past(code_i));

  p_empty_clean_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> code_o == CAUSE_NONE);
endmodule

// File: rtl/exc_commit_arb.sv
module exc_commit_arb
  import exc_pkg::*;
(
  input  logic   valid_i,
  input  cause_e code_i,
  input  logic   daddr_fault_i,
  input  logic   irq_i,
  output logic   take_o,
  output cause_e cause_o,
  output logic   commit_o
);
  cause_e pipe_c;

  always_comb begin
    pipe_c   = merge_cause(code_i, daddr_fault_i, CAUSE_DADDR);
    cause_o  = irq_i ? CAUSE_IRQ : pipe_c;
    take_o   = valid_i && (cause_o != CAUSE_NONE);
    commit_o = valid_i && !take_o;
  end
endmodule

// File: rtl/exc_csr.sv
module exc_csr
  import exc_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  cause_e          cause_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [2:0]      cause_o,
  output logic [PC_W-1:0] epc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_o <= '0;
      epc_o   <= '0;
    end else if (we_i) begin
      cause_o <= cause_i;
      epc_o   <= pc_i;
    end
  end

  p_csr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(cause_o) && $stable(epc_o)));
endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned     PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0180
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            if_valid_i,
  input  logic [PC_W-1:0] if_pc_i,
  input  logic            if_addr_fault_i,
  input  logic            id_illegal_i,
  input  logic            ex_overflow_i,
  input  logic            mem_addr_fault_i,
  input  logic            ext_irq_i,
  output logic            kill_if_o,
  output logic            kill_id_o,
  output logic            kill_ex_o,
  output logic            kill_mem_o,
  output logic            redirect_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic            commit_o,
  output logic [PC_W-1:0] commit_pc_o,
  output logic [2:0]      cause_o,
  output logic [PC_W-1:0] epc_o
);
  localparam int unsigned MEM = N_CARRY;

  // index 0 = fetch inputs, index k = output of stage register k
  logic            vld [MEM+1];
  logic [PC_W-1:0] pcs [MEM+1];
  cause_e          cds [MEM+1];
  logic [N_CARRY-1:0] fault_v;
  logic            take;
  cause_e          take_cause;

  assign fault_v = {ex_overflow_i, id_illegal_i, if_addr_fault_i};
  assign vld[0]  = if_valid_i;
  assign pcs[0]  = if_pc_i;
  assign cds[0]  = CAUSE_NONE;

  for (genvar k = 0; k < N_CARRY; k++) begin : g_stage
    exc_stage_reg #(
      .PC_W        (PC_W),
      .LOCAL_CAUSE (stage_cause(k))
    ) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (take),
      .valid_i (vld[k]),
      .pc_i    (pcs[k]),
      .code_i  (cds[k]),
      .fault_i (fault_v[k]),
      .valid_o (vld[k+1]),
      .pc_o    (pcs[k+1]),
      .code_o  (cds[k+1])
    );
  end

  exc_commit_arb u_arb (
    .valid_i       (vld[MEM]),
    .code_i        (cds[MEM]),
    .daddr_fault_i (mem_addr_fault_i),
    .irq_i         (ext_irq_i),
    .take_o        (take),
    .cause_o       (take_cause),
    .commit_o      (commit_o)
  );

  exc_csr #(.PC_W(PC_W)) u_csr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (take),
    .cause_i (take_cause),
    .pc_i    (pcs[MEM]),
    .cause_o (cause_o),
    .epc_o   (epc_o)
  );

  assign kill_if_o     = take;
  assign kill_id_o     = take;
  assign kill_ex_o     = take;
  assign kill_mem_o    = take;
  assign redirect_o    = take;
  assign redirect_pc_o = take ? HANDLER_PC : '0;
  assign commit_pc_o   = commit_o ? pcs[MEM] : '0;

  p_trap_flush_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_mem_o |=> (!vld[1] && !vld[2] && !vld[MEM]));

  p_epc_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> epc_o == $past(pcs[MEM]));

  p_irq_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_irq_i && vld[MEM]) |=> cause_o == 3'(CAUSE_IRQ));

  p_no_retire_on_kill_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_mem_o |-> !commit_o);
endmodule

// File: tb/exc_commit_ctrl_tb.sv
module exc_commit_ctrl_tb;
  localparam int PC_W = 32;
  localparam logic [31:0] HANDLER = 32'h0000_0180;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic if_valid = 0, if_fault = 0, id_ill = 0, ex_ovf = 0, mem_fault = 0, irq = 0;
  logic [31:0] if_pc = '0;
  logic k_if, k_id, k_ex, k_mem, redir, commit;
  logic [31:0] redir_pc, commit_pc, epc;
  logic [2:0] cause;

  int checks = 0;
  int errors = 0;
  logic [2:0]  exp_cause = '0;
  logic [31:0] exp_epc = '0;

  always #4 clk = ~clk;

  exc_commit_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .if_valid_i(if_valid), .if_pc_i(if_pc), .if_addr_fault_i(if_fault),
    .id_illegal_i(id_ill), .ex_overflow_i(ex_ovf), .mem_addr_fault_i(mem_fault),
    .ext_irq_i(irq),
    .kill_if_o(k_if), .kill_id_o(k_id), .kill_ex_o(k_ex), .kill_mem_o(k_mem),
    .redirect_o(redir), .redirect_pc_o(redir_pc),
    .commit_o(commit), .commit_pc_o(commit_pc),
    .cause_o(cause), .epc_o(epc)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    if_valid = 0; if_fault = 0; id_ill = 0; ex_ovf = 0; mem_fault = 0; irq = 0;
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic quiet(input string req);
    #1;
    chk(!k_mem && !k_if && !k_id && !k_ex, req, {28'd0, k_if, k_id, k_ex, k_mem}, 0);
    chk(!redir, req, {31'd0, redir}, 0);
    chk(!commit, req, {31'd0, commit}, 0);
  endtask

  task automatic csr_chk(input string req);
    #1;
    chk(cause == exp_cause, req, {29'd0, cause}, {29'd0, exp_cause});
    chk(epc == exp_epc, req, epc, exp_epc);
  endtask

  initial begin
    #1_600_000;
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clr();
    nxt(); nxt();
    // R8 reset state
    quiet("R8");
    csr_chk("R8");
    rst_n = 1'b1;
    nxt();

    // R1 R2 R3 R4 R5 R6: sweep isolated instruction over all flag sets
    for (int m = 0; m < 32; m++) begin
      logic [31:0] p;
      logic [2:0]  ec;
      p = 32'h1000 + 32'(m) * 16;
      ec = m[4] ? 3'd1 : m[0] ? 3'd2 : m[1] ? 3'd3 : m[2] ? 3'd4 : m[3] ? 3'd5 : 3'd0;
      clr(); if_valid = 1; if_pc = p; if_fault = m[0];
      nxt(); clr(); id_ill = m[1];
      nxt(); clr(); ex_ovf = m[2];
      nxt(); clr(); mem_fault = m[3]; irq = m[4];
      #1;
      if (ec != 0) begin
        chk(k_if && k_id && k_ex && k_mem, "R5", {28'd0, k_if, k_id, k_ex, k_mem}, 32'hF);
        chk(!commit, "R5", {31'd0, commit}, 0);
        chk(redir && redir_pc == HANDLER, "R6", redir_pc, HANDLER);
        exp_cause = ec; exp_epc = p;
      end else begin
        chk(commit && commit_pc == p, "R1", commit_pc, p);
        chk(!redir && !k_mem, "R6", {31'd0, redir}, 0);
      end
      nxt(); clr();
      // R2 R3 R4 recorded cause and pc
      csr_chk(ec == 1 ? "R3" : "R2");
      // R7 flags on an empty pipeline are ignored
      if_fault = 1; id_ill = 1; ex_ovf = 1; mem_fault = 1; irq = 1;
      quiet("R7");
      nxt(); clr();
      csr_chk("R4");
    end

    // R5 back-to-back stream: A traps on overflow, faulting younger B C D vanish
    clr(); if_valid = 1; if_pc = 32'h2000;
    nxt(); if_pc = 32'h2004;
    nxt(); if_pc = 32'h2008; ex_ovf = 1; id_ill = 1;
    nxt(); if_pc = 32'h200C; if_fault = 1; ex_ovf = 1; id_ill = 1;
    #1;
    chk(k_mem && redir, "R5", {31'd0, k_mem}, 1);
    exp_cause = 3'd4; exp_epc = 32'h2000;
    nxt(); clr(); if_valid = 1; if_pc = HANDLER; ex_ovf = 1; id_ill = 1;
    csr_chk("R5");
    quiet("R5");
    nxt(); clr(); if_valid = 1; if_pc = HANDLER + 4; ex_ovf = 1; mem_fault = 1;
    quiet("R5");
    nxt(); clr(); if_valid = 1; if_pc = HANDLER + 8; mem_fault = 1;
    quiet("R5");
    nxt(); clr(); if_valid = 1; if_pc = HANDLER + 12;
    #1;
    // R1 first handler fetch commits three cycles after acceptance
    chk(commit && commit_pc == HANDLER, "R1", commit_pc, HANDLER);
    nxt(); clr();
    #1;
    chk(commit && commit_pc == HANDLER + 4, "R1", commit_pc, HANDLER + 4);
    nxt();
    #1;
    chk(commit && commit_pc == HANDLER + 8, "R1", commit_pc, HANDLER + 8);
    nxt();
    // R3 interrupt taken on occupied commit point
    irq = 1;
    #1;
    chk(commit == 0 && redir == 1, "R3", {31'd0, redir}, 1);
    exp_cause = 3'd1; exp_epc = HANDLER + 12;
    nxt(); clr();
    csr_chk("R3");
    nxt();
    csr_chk("R4");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule